// File: doc/BRIEF.md
# Per-Unit Issue Lock Scoreboard

This block sits in the issue stage of a multi-warp GPU core. Each offered micro-op carries a warp index, a target execution unit, a destination register with a write flag, up to three source registers with their own enables, and a two-bit lock tag. The block accepts the micro-op with a valid/ready handshake. It withholds ready while that micro-op would read or overwrite a register that is still waiting for a result. It also withholds ready while the target unit is reserved by a different warp.

A reservation lets one warp own one execution unit for the whole of a multi-micro-op sequence. Each unit keeps only a held bit and the index of the owning warp, so no unit-by-warp matrix is stored. A unit reserved by one warp does not block other warps that issue to other units. Writeback notifications clear the pending bit for a warp and register, and a writeback in the same cycle as an issue already counts for that issue.

Top module: `unit_lock_scoreboard`

## Requirements
- R1: A synchronous reset releases every unit and clears every pending register, so ready is high in the first cycle after reset.
- R2: Ready depends only on the offered fields and the stored state, never on in_valid. Ready is low whenever a stall condition holds, even with in_valid low.
- R3: Lock tag values are 2'b10 first, 2'b00 middle, 2'b01 last and 2'b11 single. Accepting a 2'b10 micro-op reserves its unit for its warp from the next cycle. Every micro-op of another warp to that unit is then stalled, whatever its tag.
- R4: A unit reserved by one warp does not stall any warp issuing to a different unit.
- R5: Micro-ops from the owning warp to its reserved unit are stalled only by register hazards.
- R6: Accepting the owner's 2'b01 micro-op releases the unit from the next cycle.
- R7: Accepting a 2'b11 micro-op leaves the unit free for other warps.
- R8: Accepting a micro-op with its write flag set marks its destination register pending for its warp. A later micro-op of that warp is stalled if any enabled source, or its destination when writing, is pending.
- R9: A writeback clears only the register of the matching warp. The same register of other warps is unaffected.
- R10: A writeback for a register in the same cycle as an issue that uses it lets the issue proceed.
- R11: A micro-op with its write flag clear marks nothing pending, and a disabled source never causes a stall.
- R12: If an accepted write and a writeback hit the same warp and register in the same cycle, the register stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Micro-op offered |
| in_ready | output | 1 | Micro-op may be accepted this cycle |
| in_warp | input | WARP_W | Warp index |
| in_unit | input | UNIT_W | Target execution unit |
| in_rd | input | REG_W | Destination register |
| in_wr_en | input | 1 | Micro-op writes in_rd |
| in_rs | input | NUM_SRCS*REG_W | Source registers, source s at bits [s*REG_W +: REG_W] |
| in_rs_vld | input | NUM_SRCS | Per-source enable |
| in_tag | input | 2 | Lock tag |
| wb_valid | input | 1 | Writeback notification |
| wb_warp | input | WARP_W | Writeback warp |
| wb_reg | input | REG_W | Writeback register |

## Verification
The bench reserves a unit and then offers micro-ops of foreign warps to the same unit and to other units. A design that kept one lock for all units would stall the memory-unit load. A design without an owner index would let a foreign single micro-op pass. It checks the same-cycle writeback bypass and the same-cycle set against clear: a wrong priority either stalls a ready read or loses a fresh write. It also checks that writebacks to another warp, writes with the flag clear and disabled sources change nothing, since a design that decoded any of these loosely would stall or free the wrong micro-op.

// File: rtl/lksb_pkg.sv
package lksb_pkg;
   typedef enum logic [1:0] {
      TAG_MID   = 2'b00,
      TAG_LAST  = 2'b01,
      TAG_FIRST = 2'b10,
      TAG_SOLO  = 2'b11
   } lock_tag_e;
endpackage

// File: rtl/unit_lock_table.sv
module unit_lock_table #(
   parameter int NUM_UNITS = 4,
   parameter int NUM_WARPS = 4,
   localparam int UNIT_W = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1,
   localparam int WARP_W = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              fire,
   input  logic [UNIT_W-1:0] req_unit,
   input  logic [WARP_W-1:0] req_warp,
   input  logic [1:0]        req_tag,
   output logic              lock_stall
);
   import lksb_pkg::*;

   logic [NUM_UNITS-1:0] conflict;

   for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
      logic              held_q;
      logic [WARP_W-1:0] owner_q;
      logic              hit;

      assign hit = fire && (req_unit == UNIT_W'(u));

      always_ff @(posedge clk) begin
         if (rst) begin
            held_q  <= 1'b0;
            owner_q <= '0;
         end else if (hit) begin
            if (req_tag == TAG_FIRST) begin
               held_q  <= 1'b1;
               owner_q <= req_warp;
            end else if (req_tag == TAG_LAST && owner_q == req_warp) begin
               held_q  <= 1'b0;
            end
         end
      end

      assign conflict[u] = held_q && (owner_q != req_warp);
   end

   assign lock_stall = conflict[req_unit];
endmodule

// File: rtl/reg_pend_table.sv
module reg_pend_table #(
   parameter int NUM_WARPS = 4,
   parameter int NUM_REGS  = 32,
   parameter int NUM_SRCS  = 3,
   localparam int WARP_W = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1,
   localparam int REG_W  = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
   input  logic                      clk,
   input  logic                      rst,
   input  logic                      set_en,
   input  logic [WARP_W-1:0]         q_warp,
   input  logic [REG_W-1:0]          q_rd,
   input  logic                      q_wr,
   input  logic [NUM_SRCS*REG_W-1:0] q_rs,
   input  logic [NUM_SRCS-1:0]       q_rs_vld,
   input  logic                      clr_en,
   input  logic [WARP_W-1:0]         clr_warp,
   input  logic [REG_W-1:0]          clr_reg,
   output logic                      hazard
);
   logic [NUM_REGS-1:0] pend_all [NUM_WARPS];

   for (genvar w = 0; w < NUM_WARPS; w++) begin : g_warp
      logic [NUM_REGS-1:0] bits_q;

      always_ff @(posedge clk) begin
         if (rst) begin
            bits_q <= '0;
         end else begin
            if (clr_en && clr_warp == WARP_W'(w))
               bits_q[clr_reg] <= 1'b0;
            if (set_en && q_warp == WARP_W'(w))
               bits_q[q_rd] <= 1'b1;
         end
      end

      assign pend_all[w] = bits_q;
   end

   logic [NUM_REGS-1:0] clr_mask;
   logic [NUM_REGS-1:0] live;

   always_comb begin
      clr_mask = '0;
      if (clr_en && clr_warp == q_warp)
         clr_mask[clr_reg] = 1'b1;
      live = pend_all[q_warp] & ~clr_mask;
   end

   always_comb begin
      hazard = q_wr && live[q_rd];
      for (int s = 0; s < NUM_SRCS; s++) begin
         if (q_rs_vld[s] && live[q_rs[s*REG_W +: REG_W]])
            hazard = 1'b1;
      end
   end
endmodule

// File: rtl/unit_lock_scoreboard.sv
module unit_lock_scoreboard #(
   parameter int NUM_WARPS = 4,
   parameter int NUM_UNITS = 4,
   parameter int NUM_REGS  = 32,
   parameter int NUM_SRCS  = 3,
   localparam int WARP_W = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1,
   localparam int UNIT_W = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1,
   localparam int REG_W  = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
   input  logic                      clk,
   input  logic                      rst,
   input  logic                      in_valid,
   output logic                      in_ready,
   input  logic [WARP_W-1:0]         in_warp,
   input  logic [UNIT_W-1:0]         in_unit,
   input  logic [REG_W-1:0]          in_rd,
   input  logic                      in_wr_en,
   input  logic [NUM_SRCS*REG_W-1:0] in_rs,
   input  logic [NUM_SRCS-1:0]       in_rs_vld,
   input  logic [1:0]                in_tag,
   input  logic                      wb_valid,
   input  logic [WARP_W-1:0]         wb_warp,
   input  logic [REG_W-1:0]          wb_reg
);
   if ((1 << WARP_W) != NUM_WARPS || NUM_WARPS < 2) begin : g_bad_warps
      $error("NUM_WARPS must be a power of two of at least 2");
   end
   if ((1 << UNIT_W) != NUM_UNITS || NUM_UNITS < 2) begin : g_bad_units
      $error("NUM_UNITS must be a power of two of at least 2");
   end
   if ((1 << REG_W) != NUM_REGS || NUM_REGS < 2) begin : g_bad_regs
      $error("NUM_REGS must be a power of two of at least 2");
   end
   if (NUM_SRCS < 1) begin : g_bad_srcs
      $error("NUM_SRCS must be at least 1");
   end

   logic lock_stall;
   logic reg_hazard;
   logic fire;

   assign in_ready = !(lock_stall || reg_hazard);
   assign fire     = in_valid && in_ready;

   unit_lock_table #(
      .NUM_UNITS(NUM_UNITS),
      .NUM_WARPS(NUM_WARPS)
   ) u_locks (
      .clk        (clk),
      .rst        (rst),
      .fire       (fire),
      .req_unit   (in_unit),
      .req_warp   (in_warp),
      .req_tag    (in_tag),
      .lock_stall (lock_stall)
   );

   reg_pend_table #(
      .NUM_WARPS(NUM_WARPS),
      .NUM_REGS (NUM_REGS),
      .NUM_SRCS (NUM_SRCS)
   ) u_pend (
      .clk      (clk),
      .rst      (rst),
      .set_en   (fire && in_wr_en),
      .q_warp   (in_warp),
      .q_rd     (in_rd),
      .q_wr     (in_wr_en),
      .q_rs     (in_rs),
      .q_rs_vld (in_rs_vld),
      .clr_en   (wb_valid),
      .clr_warp (wb_warp),
      .clr_reg  (wb_reg),
      .hazard   (reg_hazard)
   );
endmodule

// File: rtl/unit_lock_scoreboard_chk.sv
module unit_lock_scoreboard_chk #(
   parameter int NUM_WARPS = 4,
   parameter int NUM_UNITS = 4,
   parameter int NUM_REGS  = 32,
   parameter int NUM_SRCS  = 3,
   localparam int WARP_W = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1,
   localparam int UNIT_W = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1,
   localparam int REG_W  = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
   input logic                      clk,
   input logic                      rst,
   input logic                      in_valid,
   input logic                      in_ready,
   input logic [WARP_W-1:0]         in_warp,
   input logic [UNIT_W-1:0]         in_unit,
   input logic [REG_W-1:0]          in_rd,
   input logic                      in_wr_en,
   input logic [NUM_SRCS*REG_W-1:0] in_rs,
   input logic [NUM_SRCS-1:0]       in_rs_vld,
   input logic [1:0]                in_tag,
   input logic                      wb_valid,
   input logic [WARP_W-1:0]         wb_warp,
   input logic [REG_W-1:0]          wb_reg
);
   // R1
   post_reset_ready_chk: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> in_ready);

   // R2
   valid_indep_chk: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && !$past(in_valid) && !$past(wb_valid) && !wb_valid &&
       $stable({in_warp, in_unit, in_rd, in_wr_en, in_rs, in_rs_vld, in_tag}))
      |-> (in_ready == $past(in_ready)));

   // R3
   foreign_lock_chk: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(in_valid && in_ready && in_tag == 2'b10) &&
       in_unit == $past(in_unit) && in_warp != $past(in_warp))
      |-> !in_ready);

   // R8 R12
   pending_write_chk: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(in_valid && in_ready && in_wr_en) && in_wr_en &&
       in_warp == $past(in_warp) && in_rd == $past(in_rd) &&
       !(wb_valid && wb_warp == in_warp && wb_reg == in_rd))
      |-> !in_ready);
endmodule

bind unit_lock_scoreboard unit_lock_scoreboard_chk #(
   .NUM_WARPS(NUM_WARPS),
   .NUM_UNITS(NUM_UNITS),
   .NUM_REGS (NUM_REGS),
   .NUM_SRCS (NUM_SRCS)
) u_chk (.*);

// File: tb/tb_unit_lock_scoreboard.sv
`timescale 1ns/1ps
module tb_unit_lock_scoreboard;
   localparam int NW = 4, NU = 4, NR = 32, NS = 3;
   localparam int WW = 2, UW = 2, RW = 5;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic in_valid = 1'b0;
   logic in_ready;
   logic [WW-1:0] in_warp = '0;
   logic [UW-1:0] in_unit = '0;
   logic [RW-1:0] in_rd = '0;
   logic in_wr_en = 1'b0;
   logic [NS*RW-1:0] in_rs = '0;
   logic [NS-1:0] in_rs_vld = '0;
   logic [1:0] in_tag = 2'b11;
   logic wb_valid = 1'b0;
   logic [WW-1:0] wb_warp = '0;
   logic [RW-1:0] wb_reg = '0;

   always #2.5 clk = ~clk;

   unit_lock_scoreboard #(.NUM_WARPS(NW), .NUM_UNITS(NU), .NUM_REGS(NR), .NUM_SRCS(NS)) dut (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
      .in_warp(in_warp), .in_unit(in_unit), .in_rd(in_rd), .in_wr_en(in_wr_en),
      .in_rs(in_rs), .in_rs_vld(in_rs_vld), .in_tag(in_tag),
      .wb_valid(wb_valid), .wb_warp(wb_warp), .wb_reg(wb_reg));

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   bit    exp_q[$];
   string req_q[$];

   // Driver: offer one micro-op for one cycle and queue the expected ready
   task automatic step(input bit v, input int w, input int u, input int rd, input bit we,
                       input int rs0, input bit rsv0, input int tag,
                       input bit wbv, input int wbw, input int wbr,
                       input bit exp, input string req);
      @(posedge clk);
      #1;
      in_valid  = v;
      in_warp   = WW'(w);
      in_unit   = UW'(u);
      in_rd     = RW'(rd);
      in_wr_en  = we;
      in_rs     = '0;
      in_rs[RW-1:0] = RW'(rs0);
      in_rs_vld = {2'b00, rsv0};
      in_tag    = 2'(tag);
      wb_valid  = wbv;
      wb_warp   = WW'(wbw);
      wb_reg    = RW'(wbr);
      exp_q.push_back(exp);
      req_q.push_back(req);
   endtask

   // Monitor: compare ready in mid-cycle
   always @(negedge clk) begin
      if (exp_q.size() > 0) begin
         bit e;
         string r;
         e = exp_q.pop_front();
         r = req_q.pop_front();
         checks++;
         if (in_ready !== e) begin
            errors++;
            $display("FAIL %s: in_ready=%0b expected %0b", r, in_ready, e);
         end
      end
   end

   task automatic finish_run();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: run did not complete, got hang expected end");
         finish_run();
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst = 1'b0;
      //   v  w  u  rd we rs rv tag wb ww wr exp
      step(0, 0, 0, 0, 0, 0, 0, 3, 0, 0, 0, 1, "R1 ready after reset");
      step(1, 0, 3, 0, 0, 0, 0, 2, 0, 0, 0, 1, "R3 first uop accepted");
      step(1, 1, 3, 0, 0, 0, 0, 3, 0, 0, 0, 0, "R3 foreign single to locked unit");
      step(0, 1, 3, 0, 0, 0, 0, 3, 0, 0, 0, 0, "R2 stall visible with valid low");
      step(1, 1, 2, 5, 1, 0, 0, 3, 0, 0, 0, 1, "R4 foreign load to other unit");
      step(1, 0, 3, 0, 0, 0, 0, 0, 0, 0, 0, 1, "R5 owner middle uop");
      step(1, 2, 3, 0, 0, 0, 0, 2, 0, 0, 0, 0, "R3 foreign first to locked unit");
      step(1, 1, 0, 0, 0, 5, 1, 3, 0, 0, 0, 0, "R8 read of pending register");
      step(1, 1, 0, 5, 1, 0, 0, 3, 0, 0, 0, 0, "R8 write to pending register");
      step(1, 2, 0, 0, 0, 5, 1, 3, 0, 0, 0, 1, "R9 other warp same register free");
      step(1, 1, 0, 0, 0, 5, 1, 3, 1, 1, 5, 1, "R10 same-cycle writeback bypass");
      step(1, 1, 0, 0, 0, 5, 1, 3, 0, 0, 0, 1, "R9 register cleared by writeback");
      step(1, 0, 3, 0, 0, 0, 0, 1, 0, 0, 0, 1, "R6 owner last uop");
      step(1, 1, 3, 0, 0, 0, 0, 3, 0, 0, 0, 1, "R6 unit free after release");
      step(1, 2, 3, 0, 0, 0, 0, 3, 0, 0, 0, 1, "R7 single leaves unit free");
      step(1, 3, 1, 7, 1, 0, 0, 3, 0, 0, 0, 1, "R8 write issues");
      step(1, 3, 1, 0, 0, 7, 1, 3, 1, 2, 7, 0, "R9 writeback of other warp ignored");
      step(1, 3, 1, 0, 0, 7, 1, 3, 0, 0, 0, 0, "R9 register still pending");
      step(1, 3, 1, 8, 1, 0, 0, 3, 1, 3, 8, 1, "R12 write with same-cycle clear");
      step(1, 3, 1, 0, 0, 8, 1, 3, 0, 0, 0, 0, "R12 set wins over clear");
      step(1, 3, 1, 9, 0, 0, 0, 3, 0, 0, 0, 1, "R11 non-writing uop");
      step(1, 3, 1, 0, 0, 9, 1, 3, 0, 0, 0, 1, "R11 nothing marked pending");
      step(1, 3, 1, 0, 0, 7, 0, 3, 0, 0, 0, 1, "R11 disabled source ignored");
      step(1, 2, 3, 0, 0, 0, 0, 2, 0, 0, 0, 1, "R3 second warp locks unit");
      step(1, 2, 3, 10, 1, 0, 0, 0, 0, 0, 0, 1, "R5 owner middle write");
      step(1, 2, 3, 0, 0, 10, 1, 1, 0, 0, 0, 0, "R5 owner stalled by register hazard");
      step(1, 2, 3, 0, 0, 10, 1, 1, 1, 2, 10, 1, "R5 owner last with bypass");
      step(1, 0, 3, 0, 0, 0, 0, 3, 0, 0, 0, 1, "R6 released for other warp");
      step(0, 0, 0, 0, 0, 0, 0, 3, 0, 0, 0, 1, "R1 idle");
      @(negedge clk);
      #1;
      done = 1'b1;
      finish_run();
   end
endmodule